// File: doc/BRIEF.md
# Daisy-chainable converter serial port

This block is the digital serial port of one 18-bit sampling converter that can be chained with identical ports on a three-wire bus. It sees a conversion-start line (`cnv`), a serial clock (`sck`) and a serial input (`sdi`). It drives a single serial output (`sdo`). All of these are sampled on the system clock, and `sck` and `cnv` edges are found by comparing each sample with the one before. The conversion itself is a stand-in. A counter runs for `CONV_CYCLES` clocks, and when it ends the port latches the parallel `result` word into its shift register.

A conversion starts only when `cnv` rises while `sck` is high. That condition also selects the chained mode with a busy indicator. Once the local conversion is over, `sdo` repeats `sdi`, which acts as the busy-done flag. Because of this, the flag at the port nearest the host rises only when every port upstream has also finished. The first port in the chain has its `sdi` tied to `cnv`. The host then sends `sck` pulses.
- The first falling edge of `sck` ends the flag phase and presents the local MSB.
- Each later falling edge shifts the register one place. The local word leaves MSB first and `sdi` enters at the bottom, so upstream words follow the local one.

Lowering `cnv` returns the port to idle.

Top module: `chain_adc_port`

## Requirements
- R1: After reset, and whenever `cnv` and `sdi` are both low, `sdo` is low.
- R2: A rising edge of `cnv` that is sampled while `sck` is high starts a conversion lasting `CONV_CYCLES` clocks, counted from the clock that samples the edge. `sdo` stays low throughout the conversion, whatever the level of `sdi`.
- R3: A rising edge of `cnv` sampled while `sck` is low starts nothing. `sdo` stays low for as long as `cnv` remains high, whatever happens on `sdi` and `sck`.
- R4: After the conversion ends and before the first `sck` falling edge, `sdo` equals `sdi`, the busy-done indicator. In a chain, the host-side `sdo` therefore rises only after the slowest upstream port has finished.
- R5: At the end of the conversion the 18-bit `result` is latched. The first `sck` falling edge after that presents `result[17]` on `sdo` without taking in any bit from `sdi`.
- R6: Each later `sck` falling edge shifts the word toward the MSB. `sdo` shows `result[16]` down to `result[0]` in turn, and then the `sdi` bits in the order they were sampled, the first of them sampled on the second falling edge.
- R7: While `cnv` is low, `sdo` is low. One clock after `cnv` is sampled low, any conversion or readback is abandoned, and a new conversion needs a fresh qualifying `cnv` rise.
- R8: Two chained ports read out as one 36-bit word: the host-side word first, then the upstream word, both MSB first.
- R9: `sck` falling edges during a conversion neither shift nor disturb the result that is later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all other inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Conversion start; stays high through conversion and readback |
| sck | input | 1 | Serial clock from the host; falling edges shift data |
| sdi | input | 1 | Serial input from the upstream port (tied to `cnv` on the first port) |
| result | input | WIDTH | Conversion result from the behavioural converter stub |
| sdo | output | 1 | Busy-done flag, then serial data, MSB first |

## Verification
A wrong phase state would show at once on `sdo`. A port left in the flag phase mirrors `sdi` instead of presenting data. A port that skips the flag phase drops the MSB, and the whole readback then appears one bit early. A miscounted conversion length moves the rise of the busy flag by the same number of clocks. The bench checks the exact clock of that rise. A shift register that takes in `sdi` on the wrong edge corrupts the bit that follows. In the chained readback this shows as an upstream word shifted by one bit, visible within the first 19 falling edges of `sck`.

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
  parameter int WIDTH       = 18,
  parameter int CONV_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv,
  input  logic             sck,
  input  logic             sdi,
  input  logic [WIDTH-1:0] result,
  output logic             sdo
);

  localparam int CW = $clog2(CONV_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_FLAG, ST_SHIFT} phase_t;

  phase_t           st;
  logic             cnv_q, sck_q;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] shreg;

  wire cnv_rise = cnv & ~cnv_q;
  wire sck_fall = sck_q & ~sck;
  wire conv_end = (cnt == CW'(CONV_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else begin
      cnv_q <= cnv;
      sck_q <= sck;
      if (!cnv) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE:
            if (cnv_rise && sck) begin
              st  <= ST_CONV;
              cnt <= '0;
            end
          ST_CONV:
            if (conv_end) begin
              st    <= ST_FLAG;
              shreg <= result;
            end else begin
              cnt <= cnt + 1'b1;
            end
          ST_FLAG:
            if (sck_fall) st <= ST_SHIFT;
          default:
            if (sck_fall) shreg <= {shreg[WIDTH-2:0], sdi};
        endcase
      end
    end
  end

  assign sdo = cnv & (((st == ST_FLAG) & sdi) | ((st == ST_SHIFT) & shreg[WIDTH-1]));

  assert_cnv_low_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv |=> (st == ST_IDLE));

  assert_conv_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONV && cnv && !conv_end) |=> (st == ST_CONV));

  assert_no_start_sck_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cnv_rise && !sck) |=> (st == ST_IDLE));

  assert_load_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONV && cnv && conv_end) |=> (st == ST_FLAG && shreg == $past(result)));

  assert_flag_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLAG && cnv && !sck_fall) |=> (st == ST_FLAG));

  assert_shift_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT && cnv && sck_fall) |=> (sdo == $past(shreg[WIDTH-2])));

endmodule

// File: tb/tb_chain_adc_port.sv
module tb_chain_adc_port;
  localparam int W      = 18;
  localparam int CONV   = 20;
  localparam int CONV_U = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0;
  logic sck = 1'b1;
  logic sdi_drv = 1'b0;
  logic use_chain = 1'b0;
  logic [W-1:0] result = '0;
  logic [W-1:0] result_up = '0;
  logic sdo, up_sdo, dut_sdi;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  assign dut_sdi = use_chain ? up_sdo : sdi_drv;

  chain_adc_port #(.WIDTH(W), .CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(dut_sdi),
    .result(result), .sdo(sdo));

  chain_adc_port #(.WIDTH(W), .CONV_CYCLES(CONV_U)) upstream (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(cnv),
    .result(result_up), .sdo(up_sdo));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sck_pulse(input logic din, output logic seen);
    sck = 1'b0;
    sdi_drv = din;
    tick();
    seen = sdo;
    sck = 1'b1;
    tick();
  endtask

  task automatic go_idle();
    cnv = 1'b0;
    sdi_drv = 1'b0;
    sck = 1'b1;
    use_chain = 1'b0;
    tick();
    tick();
  endtask

  function automatic logic pat(input int j);
    return (j % 3 == 0);
  endfunction

  task automatic t_reset();
    logic bad = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (sdo !== 1'b0) bad = 1'b1;
      tick();
    end
    check("R1 idle sdo after reset", bad, 1'b0);
  endtask

  task automatic t_conv_and_read();
    logic seen, bad;
    logic [W-1:0] got;
    result = 18'h2D5A3;
    sdi_drv = 1'b1;
    sck = 1'b1;
    cnv = 1'b1;
    tick();
    bad = 1'b0;
    for (int i = 0; i < CONV - 1; i++) begin
      if (sdo !== 1'b0) bad = 1'b1;
      tick();
    end
    check("R2 sdo low during conversion", bad, 1'b0);
    check("R2 still converting at last cycle", sdo, 1'b0);
    tick();
    check("R4 busy flag follows sdi high", sdo, 1'b1);
    sdi_drv = 1'b0;
    tick();
    check("R4 busy flag follows sdi low", sdo, 1'b0);
    result = 18'h00000;
    sdi_drv = 1'b1;
    tick();
    got = '0;
    sck_pulse(1'b1, seen);
    check("R5 first fall shows MSB", seen, 1'b1);
    got[W-1] = seen;
    for (int k = 2; k <= W; k++) begin
      sck_pulse(pat(k - 2), seen);
      got[W-k] = seen;
    end
    check("R6 local word MSB first", got, 18'h2D5A3);
    got = '0;
    for (int j = 1; j <= W; j++) begin
      sck_pulse(1'b0, seen);
      got[W-j] = seen;
    end
    check("R6/R5 sdi bits follow in order", got,
          {pat(0), pat(1), pat(2), pat(3), pat(4), pat(5), pat(6), pat(7), pat(8),
           pat(9), pat(10), pat(11), pat(12), pat(13), pat(14), pat(15), pat(16), 1'b0});
    go_idle();
  endtask

  task automatic t_no_start();
    logic seen;
    logic bad = 1'b0;
    sck = 1'b0;
    tick();
    cnv = 1'b1;
    sdi_drv = 1'b1;
    for (int i = 0; i < CONV + 6; i++) begin
      if (sdo !== 1'b0) bad = 1'b1;
      tick();
    end
    sck = 1'b1;
    tick();
    for (int i = 0; i < 4; i++) begin
      sck_pulse(1'b1, seen);
      if (seen !== 1'b0) bad = 1'b1;
    end
    check("R3 cnv rise with sck low starts nothing", bad, 1'b0);
    go_idle();
  endtask

  task automatic t_abort();
    logic seen;
    logic bad = 1'b0;
    result = 18'h3FFFF;
    sdi_drv = 1'b1;
    cnv = 1'b1;
    tick();
    repeat (5) tick();
    cnv = 1'b0;
    #1;
    check("R7 sdo low when cnv drops", sdo, 1'b0);
    tick();
    sck = 1'b0;
    tick();
    cnv = 1'b1;
    for (int i = 0; i < CONV + 4; i++) begin
      if (sdo !== 1'b0) bad = 1'b1;
      tick();
    end
    check("R7 aborted conversion leaves no busy", bad, 1'b0);
    go_idle();
    cnv = 1'b1;
    tick();
    repeat (CONV) tick();
    sck_pulse(1'b0, seen);
    check("R7 fresh conversion reads MSB", seen, 1'b1);
    cnv = 1'b0;
    sdi_drv = 1'b1;
    tick();
    check("R1 sdo low with cnv low after readback", sdo, 1'b0);
    go_idle();
  endtask

  task automatic t_sck_during_conv();
    logic seen;
    logic [W-1:0] got;
    logic dummy;
    result = 18'h1A5C3;
    cnv = 1'b1;
    tick();
    for (int i = 0; i < 4; i++) sck_pulse(1'b1, dummy);
    repeat (CONV) tick();
    sdi_drv = 1'b1;
    #1;
    check("R9 busy flag after sck activity", sdo, 1'b1);
    got = '0;
    for (int k = 1; k <= W; k++) begin
      sck_pulse(1'b0, seen);
      got[W-k] = seen;
    end
    check("R9 result intact after sck during conversion", got, 18'h1A5C3);
    go_idle();
  endtask

  task automatic t_chain();
    logic seen;
    logic [2*W-1:0] got;
    use_chain = 1'b1;
    result = 18'h25A5C;
    result_up = 18'h1C3F1;
    sck = 1'b1;
    cnv = 1'b1;
    tick();
    repeat (CONV_U - 1) tick();
    check("R4 host-side flag waits for upstream", sdo, 1'b0);
    tick();
    check("R4 host-side flag rises when all done", sdo, 1'b1);
    got = '0;
    for (int k = 1; k <= 2 * W; k++) begin
      sck_pulse(1'b0, seen);
      got[2*W-k] = seen;
    end
    check("R8 host-side word", got[2*W-1:W], 18'h25A5C);
    check("R8 upstream word", got[W-1:0], 18'h1C3F1);
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conv_and_read();
    t_no_start();
    t_abort();
    t_sck_during_conv();
    t_chain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule